// File: doc/BRIEF.md
# Dual-Issue Packet Hazard Unit

This block sits in the decode stage of a statically scheduled two-issue pipeline. Each cycle it looks at the two instructions of the issue packet in decode. It sees each instruction only as pre-decoded fields: a class code, a destination, two sources and two source-use flags. It also sees the destinations and load flags of the older packets now in execute, memory and write-back.

From these fields the block reports two kinds of packet error. The first is a packet whose slot classes break the pairing rule of the active mode. The second is a packet where one instruction reads a register that its partner writes. A sticky error flag records that either error has occurred. The block raises a single stall that holds both slots whenever a data hazard cannot be covered by forwarding. It also drives forwarding-select codes for the two operands of the decode-stage branch comparator. Branch prediction is taken as perfect, so the block never requests a flush.

Class codes are NOP=0, ALU=1, BRANCH=2, MEM=3. A destination of register 0 means the instruction writes nothing, as with stores and branches. Register 0 is never a hazard and is never forwarded.

Top module: `dih_hazard_unit`

## Requirements
- R1: With `alt_mode`=0, `pkt_bad` is 1 when both slots are non-NOP and either both are MEM or neither is MEM. Otherwise the slot classes are legal.
- R2: With `alt_mode`=1, slot 0 may hold any class, while slot 1 must be ALU or NOP. Any other slot-1 class, including MEM together with MEM, sets `pkt_bad`.
- R3: `pkt_bad` is 1 when a used source of one slot equals the nonzero destination of the other slot in the same packet.
- R4: A slot whose class is NOP has its destination, sources and use flags ignored. It never causes a packet error, a stall or a forward.
- R5: `err_flag` is 0 after reset. It becomes 1 at the clock edge that samples `pkt_bad`=1 and stays 1 until a clock edge with `rst_n`=0.
- R6: `stall` is 1 when a used source of a non-NOP slot equals the nonzero destination of an execute-stage lane whose load flag is set.
- R7: `stall` is 1 when a used source of a BRANCH slot equals the nonzero destination of a non-load execute-stage lane.
- R8: `stall` is 1 when a used source of a BRANCH slot equals the nonzero destination of a memory-stage lane whose load flag is set.
- R9: `fwd_a` and `fwd_b` give the source for the rs1 and rs2 operands of the branch slot. The branch slot is slot 0 if it is BRANCH, otherwise slot 1. The codes, in priority order, are: 1 for a non-load memory-stage lane 0; 2 for a non-load memory-stage lane 1; 3 for write-back lane 0; 4 for write-back lane 1. Code 0 means the register file. A match needs a nonzero register and a set use flag. Both codes are 0 when neither slot is BRANCH.
- R10: `stall` is 0 when none of the conditions in R6, R7 or R8 holds. This includes an ALU result in execute that feeds a non-branch slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alt_mode | input | 1 | 1 selects the any-class/ALU pairing rule |
| s0_cls | input | 2 | Slot 0 class code |
| s0_rd | input | REG_W | Slot 0 destination |
| s0_rs1 | input | REG_W | Slot 0 first source |
| s0_rs2 | input | REG_W | Slot 0 second source |
| s0_use1 | input | 1 | Slot 0 reads rs1 |
| s0_use2 | input | 1 | Slot 0 reads rs2 |
| s1_cls | input | 2 | Slot 1 class code |
| s1_rd | input | REG_W | Slot 1 destination |
| s1_rs1 | input | REG_W | Slot 1 first source |
| s1_rs2 | input | REG_W | Slot 1 second source |
| s1_use1 | input | 1 | Slot 1 reads rs1 |
| s1_use2 | input | 1 | Slot 1 reads rs2 |
| ex0_rd | input | REG_W | Execute lane 0 destination |
| ex0_ld | input | 1 | Execute lane 0 is a load |
| ex1_rd | input | REG_W | Execute lane 1 destination |
| ex1_ld | input | 1 | Execute lane 1 is a load |
| mm0_rd | input | REG_W | Memory lane 0 destination |
| mm0_ld | input | 1 | Memory lane 0 is a load |
| mm1_rd | input | REG_W | Memory lane 1 destination |
| mm1_ld | input | 1 | Memory lane 1 is a load |
| wb0_rd | input | REG_W | Write-back lane 0 destination |
| wb1_rd | input | REG_W | Write-back lane 1 destination |
| pkt_bad | output | 1 | Current packet breaks a slot or dependency rule |
| err_flag | output | 1 | Sticky packet-error flag |
| stall | output | 1 | Hold both slots this cycle |
| fwd_a | output | 3 | Branch rs1 forwarding select |
| fwd_b | output | 3 | Branch rs2 forwarding select |

## Verification
The hardest situation to reach is the chain of stalls that follows a load feeding a branch. The load first sits in execute and then in memory, and after that its result is forwarded from write-back in lane 1. Reaching this needs consistent older-stage state across consecutive cycles, which random stimulus almost never produces. Directed sequences therefore replay the loop schedule packet by packet, and they set the execute, memory and write-back fields by hand to match where each instruction would have moved. Random traffic over a narrow register range then collides sources and destinations often, which exercises the priority ties between lanes and the mode rules.

// File: rtl/dih_pkg.sv
// Shared class codes, forwarding codes and lane count for the hazard unit.
// Assumes exactly two issue lanes per packet.
package dih_pkg;
    localparam int LANES  = 2;
    localparam int NSRC   = 2 * LANES;           // forwardable stage lanes
    localparam int FWD_W  = $clog2(NSRC + 1);

    typedef enum logic [1:0] {
        CLS_NOP = 2'd0,
        CLS_ALU = 2'd1,
        CLS_BR  = 2'd2,
        CLS_MEM = 2'd3
    } cls_e;
endpackage

// File: rtl/dih_slot_rules.sv
// Packet legality: slot-class pairing for the selected mode and
// intra-packet read-after-write dependencies.
// Assumes NOP slots arrive already masked (rd=0, no uses).
module dih_slot_rules #(
    parameter int REG_W = 5
) (
    input  logic                                  alt_mode,
    input  logic [dih_pkg::LANES-1:0][1:0]        cls,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  rd,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  rs1,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  rs2,
    input  logic [dih_pkg::LANES-1:0]             use1,
    input  logic [dih_pkg::LANES-1:0]             use2,
    output logic                                  class_bad,
    output logic                                  dep_bad
);
    import dih_pkg::*;

    logic [LANES-1:0] reads_other;

    // Pairing rule: default needs exactly one MEM among two real slots,
    // alternate mode needs slot 1 to be ALU or NOP.
    always_comb begin
        if (alt_mode)
            class_bad = (cls[1] != CLS_NOP) && (cls[1] != CLS_ALU);
        else
            class_bad = (cls[0] != CLS_NOP) && (cls[1] != CLS_NOP) &&
                        ((cls[0] == CLS_MEM) == (cls[1] == CLS_MEM));
    end

    // Per slot: does it read the destination of its partner.
    for (genvar s = 0; s < LANES; s++) begin : g_dep
        localparam int O = LANES - 1 - s;
        always_comb begin
            reads_other[s] = (rd[O] != '0) &&
                             ((use1[s] && (rs1[s] == rd[O])) ||
                              (use2[s] && (rs2[s] == rd[O])));
        end
    end

    assign dep_bad = |reads_other;
endmodule

// File: rtl/dih_stall_detect.sv
// Stall decision for the decode packet against older packets.
// Loads in execute stall any reader; branches also stall on an
// execute-stage ALU result and on a memory-stage load.
// Assumes rd=0 marks a lane that writes nothing.
module dih_stall_detect #(
    parameter int REG_W = 5
) (
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  rs1,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  rs2,
    input  logic [dih_pkg::LANES-1:0]             use1,
    input  logic [dih_pkg::LANES-1:0]             use2,
    input  logic [dih_pkg::LANES-1:0]             is_br,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  ex_rd,
    input  logic [dih_pkg::LANES-1:0]             ex_ld,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  mm_rd,
    input  logic [dih_pkg::LANES-1:0]             mm_ld,
    output logic                                  stall
);
    import dih_pkg::*;

    logic [LANES-1:0][LANES-1:0] hit_ex;
    logic [LANES-1:0][LANES-1:0] hit_mm;
    logic [LANES-1:0][LANES-1:0] need;

    for (genvar s = 0; s < LANES; s++) begin : g_slot
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            // Source match of slot s against older lane l in EX and MEM.
            always_comb begin
                hit_ex[s][l] = (ex_rd[l] != '0) &&
                               ((use1[s] && (rs1[s] == ex_rd[l])) ||
                                (use2[s] && (rs2[s] == ex_rd[l])));
                hit_mm[s][l] = (mm_rd[l] != '0) &&
                               ((use1[s] && (rs1[s] == mm_rd[l])) ||
                                (use2[s] && (rs2[s] == mm_rd[l])));
            end
            // Which matches cannot be covered by a forwarding path.
            always_comb begin
                need[s][l] = (hit_ex[s][l] && (ex_ld[l] || is_br[s])) ||
                             (hit_mm[s][l] && mm_ld[l] && is_br[s]);
            end
        end
    end

    assign stall = |need;
endmodule

// File: rtl/dih_fwd_select.sv
// Forwarding select for one operand of the decode-stage branch.
// Candidates in fixed priority: MEM lane 0, MEM lane 1, WB lane 0,
// WB lane 1; code 0 selects the register file. Loads in MEM are not
// candidates since their data is not ready; register 0 never matches.
module dih_fwd_select #(
    parameter int REG_W = 5
) (
    input  logic                                  active,
    input  logic [REG_W-1:0]                      src,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  mm_rd,
    input  logic [dih_pkg::LANES-1:0]             mm_ld,
    input  logic [dih_pkg::LANES-1:0][REG_W-1:0]  wb_rd,
    output logic [dih_pkg::FWD_W-1:0]             code
);
    import dih_pkg::*;

    logic [NSRC-1:0][REG_W-1:0] cand_rd;
    logic [NSRC-1:0]            cand_ok;

    for (genvar l = 0; l < LANES; l++) begin : g_cand
        // Flatten older lanes into priority order with their eligibility.
        always_comb begin
            cand_rd[l]         = mm_rd[l];
            cand_ok[l]         = !mm_ld[l];
            cand_rd[LANES + l] = wb_rd[l];
            cand_ok[LANES + l] = 1'b1;
        end
    end

    // Lowest-index match wins; walk from the lowest priority upward.
    always_comb begin
        code = '0;
        if (active && (src != '0)) begin
            for (int k = NSRC - 1; k >= 0; k--) begin
                if (cand_ok[k] && (cand_rd[k] == src))
                    code = FWD_W'(k + 1);
            end
        end
    end
endmodule

// File: rtl/dih_hazard_unit.sv
// Top of the dual-issue packet hazard unit. Masks NOP slots, combines
// the legality, stall and forwarding logic, and holds the sticky error.
// Assumes pre-decoded fields are valid every cycle and rd=0 means no write.
module dih_hazard_unit #(
    parameter int REG_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     alt_mode,
    input  logic [1:0]               s0_cls,
    input  logic [REG_W-1:0]         s0_rd,
    input  logic [REG_W-1:0]         s0_rs1,
    input  logic [REG_W-1:0]         s0_rs2,
    input  logic                     s0_use1,
    input  logic                     s0_use2,
    input  logic [1:0]               s1_cls,
    input  logic [REG_W-1:0]         s1_rd,
    input  logic [REG_W-1:0]         s1_rs1,
    input  logic [REG_W-1:0]         s1_rs2,
    input  logic                     s1_use1,
    input  logic                     s1_use2,
    input  logic [REG_W-1:0]         ex0_rd,
    input  logic                     ex0_ld,
    input  logic [REG_W-1:0]         ex1_rd,
    input  logic                     ex1_ld,
    input  logic [REG_W-1:0]         mm0_rd,
    input  logic                     mm0_ld,
    input  logic [REG_W-1:0]         mm1_rd,
    input  logic                     mm1_ld,
    input  logic [REG_W-1:0]         wb0_rd,
    input  logic [REG_W-1:0]         wb1_rd,
    output logic                     pkt_bad,
    output logic                     err_flag,
    output logic                     stall,
    output logic [2:0]               fwd_a,
    output logic [2:0]               fwd_b
);
    import dih_pkg::*;

    logic [LANES-1:0][1:0]       raw_cls;
    logic [LANES-1:0][REG_W-1:0] raw_rd, raw_rs1, raw_rs2;
    logic [LANES-1:0]            raw_u1, raw_u2;
    logic [LANES-1:0][REG_W-1:0] m_rd, m_rs1, m_rs2;
    logic [LANES-1:0]            m_u1, m_u2, is_br;
    logic [LANES-1:0][REG_W-1:0] ex_rd, mm_rd, wb_rd;
    logic [LANES-1:0]            ex_ld, mm_ld;
    logic                        class_bad, dep_bad;
    logic                        br_any;
    logic [REG_W-1:0]            br_rs1, br_rs2;
    logic                        br_u1, br_u2;
    logic [FWD_W-1:0]            code_a, code_b;

    // Gather per-lane ports into arrays.
    always_comb begin
        raw_cls = {s1_cls, s0_cls};
        raw_rd  = {s1_rd, s0_rd};
        raw_rs1 = {s1_rs1, s0_rs1};
        raw_rs2 = {s1_rs2, s0_rs2};
        raw_u1  = {s1_use1, s0_use1};
        raw_u2  = {s1_use2, s0_use2};
        ex_rd   = {ex1_rd, ex0_rd};
        ex_ld   = {ex1_ld, ex0_ld};
        mm_rd   = {mm1_rd, mm0_rd};
        mm_ld   = {mm1_ld, mm0_ld};
        wb_rd   = {wb1_rd, wb0_rd};
    end

    for (genvar s = 0; s < LANES; s++) begin : g_mask
        // A NOP slot contributes no destination and no reads.
        always_comb begin
            m_rd[s]  = (raw_cls[s] == CLS_NOP) ? '0 : raw_rd[s];
            m_rs1[s] = raw_rs1[s];
            m_rs2[s] = raw_rs2[s];
            m_u1[s]  = (raw_cls[s] != CLS_NOP) && raw_u1[s];
            m_u2[s]  = (raw_cls[s] != CLS_NOP) && raw_u2[s];
            is_br[s] = (raw_cls[s] == CLS_BR);
        end
    end

    dih_slot_rules #(.REG_W(REG_W)) u_rules (
        .alt_mode (alt_mode),
        .cls      (raw_cls),
        .rd       (m_rd),
        .rs1      (m_rs1),
        .rs2      (m_rs2),
        .use1     (m_u1),
        .use2     (m_u2),
        .class_bad(class_bad),
        .dep_bad  (dep_bad)
    );

    dih_stall_detect #(.REG_W(REG_W)) u_stall (
        .rs1  (m_rs1),
        .rs2  (m_rs2),
        .use1 (m_u1),
        .use2 (m_u2),
        .is_br(is_br),
        .ex_rd(ex_rd),
        .ex_ld(ex_ld),
        .mm_rd(mm_rd),
        .mm_ld(mm_ld),
        .stall(stall)
    );

    // Pick the branch slot: slot 0 first, else slot 1.
    always_comb begin
        br_any = |is_br;
        if (is_br[0]) begin
            br_rs1 = m_rs1[0]; br_rs2 = m_rs2[0];
            br_u1  = m_u1[0];  br_u2  = m_u2[0];
        end else begin
            br_rs1 = m_rs1[1]; br_rs2 = m_rs2[1];
            br_u1  = m_u1[1];  br_u2  = m_u2[1];
        end
    end

    dih_fwd_select #(.REG_W(REG_W)) u_fwd_a (
        .active(br_any && br_u1),
        .src   (br_rs1),
        .mm_rd (mm_rd),
        .mm_ld (mm_ld),
        .wb_rd (wb_rd),
        .code  (code_a)
    );

    dih_fwd_select #(.REG_W(REG_W)) u_fwd_b (
        .active(br_any && br_u2),
        .src   (br_rs2),
        .mm_rd (mm_rd),
        .mm_ld (mm_ld),
        .wb_rd (wb_rd),
        .code  (code_b)
    );

    // Drive the packet status and forwarding outputs.
    always_comb begin
        pkt_bad = class_bad || dep_bad;
        fwd_a   = 3'(code_a);
        fwd_b   = 3'(code_b);
    end

    // Sticky error: set by any illegal packet, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (pkt_bad)
            err_flag <= 1'b1;
    end
endmodule

// File: rtl/dih_hazard_chk.sv
// Temporal checks on the hazard unit ports, bound into every instance.
module dih_hazard_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alt_mode,
    input logic [1:0]       s0_cls,
    input logic [REG_W-1:0] s0_rs1,
    input logic             s0_use1,
    input logic [1:0]       s1_cls,
    input logic [REG_W-1:0] ex0_rd,
    input logic             ex0_ld,
    input logic             pkt_bad,
    input logic             err_flag,
    input logic             stall,
    input logic [2:0]       fwd_a,
    input logic [2:0]       fwd_b
);
    assert_err_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);

    assert_bad_sets_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_bad |=> err_flag);

    assert_reset_clears_R5: assert property (@(posedge clk)
        !rst_n |=> !err_flag);

    assert_alt_two_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_mode && s0_cls == 2'd3 && s1_cls == 2'd3) |-> pkt_bad);

    assert_load_use_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_cls != 2'd0 && s0_use1 && ex0_ld && ex0_rd != '0 && s0_rs1 == ex0_rd)
        |-> stall);

    assert_fwd_code_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_a <= 3'd4) && (fwd_b <= 3'd4));

    assert_no_fwd_without_branch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s0_cls != 2'd2 && s1_cls != 2'd2) |-> (fwd_a == 3'd0 && fwd_b == 3'd0));
endmodule

bind dih_hazard_unit dih_hazard_chk #(.REG_W(REG_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .alt_mode(alt_mode),
    .s0_cls  (s0_cls),
    .s0_rs1  (s0_rs1),
    .s0_use1 (s0_use1),
    .s1_cls  (s1_cls),
    .ex0_rd  (ex0_rd),
    .ex0_ld  (ex0_ld),
    .pkt_bad (pkt_bad),
    .err_flag(err_flag),
    .stall   (stall),
    .fwd_a   (fwd_a),
    .fwd_b   (fwd_b)
);

// File: tb/sim_dih_hazard_unit.sv
module sim_dih_hazard_unit;
    localparam int RW = 5;
    localparam logic [1:0] NOP = 2'd0, ALU = 2'd1, BR = 2'd2, MEM = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alt_mode = 1'b0;
    logic [1:0] c0 = NOP, c1 = NOP;
    logic [RW-1:0] d0 = '0, a0 = '0, b0 = '0, d1 = '0, a1 = '0, b1 = '0;
    logic u10 = 1'b0, u20 = 1'b0, u11 = 1'b0, u21 = 1'b0;
    logic [RW-1:0] e0 = '0, e1 = '0, m0 = '0, m1 = '0, w0 = '0, w1 = '0;
    logic el0 = 1'b0, el1 = 1'b0, ml0 = 1'b0, ml1 = 1'b0;
    logic pkt_bad, err_flag, stall;
    logic [2:0] fwd_a, fwd_b;

    int total = 0, bad = 0;
    logic m_err = 1'b0;
    logic done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dih_hazard_unit #(.REG_W(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .alt_mode(alt_mode),
        .s0_cls(c0), .s0_rd(d0), .s0_rs1(a0), .s0_rs2(b0), .s0_use1(u10), .s0_use2(u20),
        .s1_cls(c1), .s1_rd(d1), .s1_rs1(a1), .s1_rs2(b1), .s1_use1(u11), .s1_use2(u21),
        .ex0_rd(e0), .ex0_ld(el0), .ex1_rd(e1), .ex1_ld(el1),
        .mm0_rd(m0), .mm0_ld(ml0), .mm1_rd(m1), .mm1_ld(ml1),
        .wb0_rd(w0), .wb1_rd(w1),
        .pkt_bad(pkt_bad), .err_flag(err_flag), .stall(stall),
        .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    // Does a real slot read register r (r nonzero)?
    function automatic logic reads(logic [1:0] c, logic [RW-1:0] x, logic ux,
                                   logic [RW-1:0] y, logic uy, logic [RW-1:0] r);
        return (c != NOP) && (r != 0) && ((ux && x == r) || (uy && y == r));
    endfunction

    function automatic logic exp_class();   // R1, R2
        if (alt_mode) return (c1 != NOP) && (c1 != ALU);
        return (c0 != NOP) && (c1 != NOP) && ((c0 == MEM) == (c1 == MEM));
    endfunction

    function automatic logic exp_dep();     // R3, R4
        logic [RW-1:0] r0, r1;
        r0 = (c0 == NOP) ? '0 : d0;
        r1 = (c1 == NOP) ? '0 : d1;
        return reads(c1, a1, u11, b1, u21, r0) || reads(c0, a0, u10, b0, u20, r1);
    endfunction

    function automatic logic exp_stall();   // R6, R7, R8, R10
        logic s;
        s = 1'b0;
        s |= el0 && (reads(c0, a0, u10, b0, u20, e0) || reads(c1, a1, u11, b1, u21, e0));
        s |= el1 && (reads(c0, a0, u10, b0, u20, e1) || reads(c1, a1, u11, b1, u21, e1));
        if (c0 == BR) s |= reads(c0, a0, u10, b0, u20, e0) || reads(c0, a0, u10, b0, u20, e1) ||
                           (ml0 && reads(c0, a0, u10, b0, u20, m0)) ||
                           (ml1 && reads(c0, a0, u10, b0, u20, m1));
        if (c1 == BR) s |= reads(c1, a1, u11, b1, u21, e0) || reads(c1, a1, u11, b1, u21, e1) ||
                           (ml0 && reads(c1, a1, u11, b1, u21, m0)) ||
                           (ml1 && reads(c1, a1, u11, b1, u21, m1));
        return s;
    endfunction

    function automatic logic [2:0] exp_fwd(logic [RW-1:0] r, logic u);  // R9
        if (!u || r == 0) return 3'd0;
        if (!ml0 && m0 == r) return 3'd1;
        if (!ml1 && m1 == r) return 3'd2;
        if (w0 == r) return 3'd3;
        if (w1 == r) return 3'd4;
        return 3'd0;
    endfunction

    task automatic check(string tag, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Compare outputs with the model mid-cycle, then advance the model edge.
    task automatic step();
        logic eb, ea, ebb, es;
        logic [2:0] fa, fb;
        #1;
        eb = exp_class() || exp_dep();
        es = exp_stall();
        if (c0 == BR)      begin fa = exp_fwd(a0, u10); fb = exp_fwd(b0, u20); end
        else if (c1 == BR) begin fa = exp_fwd(a1, u11); fb = exp_fwd(b1, u21); end
        else               begin fa = 3'd0; fb = 3'd0; end
        ea = exp_dep();
        ebb = exp_class();
        check(ea ? "R3 pkt_bad" : (alt_mode ? "R2 pkt_bad" : "R1 pkt_bad"), pkt_bad, eb);
        check(es ? "R6 R7 R8 stall" : "R10 stall", stall, es);
        check("R9 fwd_a", fwd_a, fa);
        check("R9 fwd_b", fwd_b, fb);
        check("R5 err_flag", err_flag, m_err);
        if (ebb && ea) total += 0;
        @(posedge clk);
        m_err = rst_n ? (m_err | eb) : 1'b0;
        @(negedge clk);
    endtask

    task automatic clear_pkt();
        alt_mode = 0;
        c0 = NOP; c1 = NOP; d0 = 0; a0 = 0; b0 = 0; d1 = 0; a1 = 0; b1 = 0;
        u10 = 0; u20 = 0; u11 = 0; u21 = 0;
        e0 = 0; e1 = 0; m0 = 0; m1 = 0; w0 = 0; w1 = 0;
        el0 = 0; el1 = 0; ml0 = 0; ml1 = 0;
    endtask

    task automatic set_s0(logic [1:0] c, int d, int x, logic ux, int y, logic uy);
        c0 = c; d0 = RW'(d); a0 = RW'(x); u10 = ux; b0 = RW'(y); u20 = uy;
    endtask
    task automatic set_s1(logic [1:0] c, int d, int x, logic ux, int y, logic uy);
        c1 = c; d1 = RW'(d); a1 = RW'(x); u11 = ux; b1 = RW'(y); u21 = uy;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired got=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'd20211));
        @(negedge clk);
        clear_pkt();
        step();                       // reset state: err_flag 0 (R5)
        step();
        rst_n = 1;

        // Loop schedule, packet by packet, older stages set by hand.
        set_s0(ALU, 12, 0, 1, 0, 0);  step();                 // addi x12
        clear_pkt(); set_s0(BR, 0, 12, 1, 13, 1); e0 = 12;     // R7 bne vs addi in EX
        step();
        e0 = 0; m0 = 12; step();                               // after bubble: fwd_a=1 (R9)
        clear_pkt(); set_s0(ALU, 5, 12, 1, 0, 0); step();      // slli
        clear_pkt(); set_s0(ALU, 6, 10, 1, 5, 1); e0 = 5;      // R10 ALU->ALU, no stall
        step();
        clear_pkt(); set_s1(MEM, 7, 6, 1, 0, 0); e0 = 6; step(); // lw x7
        clear_pkt(); set_s1(MEM, 29, 6, 1, 0, 0); e1 = 7; el1 = 1; step(); // lw x29
        clear_pkt(); set_s0(ALU, 30, 7, 1, 29, 1); e1 = 29; el1 = 1; m1 = 7; ml1 = 1;
        step();                                                // R6 load-use stall
        clear_pkt(); set_s0(BR, 0, 12, 1, 13, 1); m1 = 12; ml1 = 1; step(); // R8
        clear_pkt(); set_s0(BR, 0, 12, 1, 13, 1); w1 = 12; step();          // R9 code 4
        clear_pkt(); set_s1(BR, 0, 0, 1, 13, 1); m0 = 13; m1 = 13; w0 = 13; step(); // R9 priority, x0
        clear_pkt(); set_s0(BR, 0, 9, 1, 0, 0); m0 = 9; ml0 = 1; w0 = 9; step(); // R8 + R9 skip load
        clear_pkt(); set_s0(NOP, 5, 7, 1, 7, 1); set_s1(ALU, 6, 5, 1, 0, 0); e0 = 7; el0 = 1;
        step();                                                // R4 NOP ignored
        clear_pkt(); alt_mode = 1; set_s0(MEM, 4, 2, 1, 0, 0); set_s1(ALU, 3, 1, 1, 0, 0);
        step();                                                // R2 legal
        clear_pkt(); set_s0(ALU, 4, 2, 1, 0, 0); set_s1(ALU, 3, 1, 1, 0, 0); step(); // R1 illegal
        step(); clear_pkt(); step();                           // R5 sticky with a legal packet
        rst_n = 0; step(); rst_n = 1; step();                  // R5 cleared by reset
        alt_mode = 1; set_s0(MEM, 4, 2, 1, 0, 0); set_s1(MEM, 0, 1, 1, 3, 1); step(); // R2 two MEM
        clear_pkt(); set_s0(ALU, 30, 7, 1, 29, 1); set_s1(MEM, 29, 6, 1, 0, 0); step(); // R3
        rst_n = 0; step(); rst_n = 1; clear_pkt();

        for (int n = 0; n < 4000; n++) begin
            alt_mode = ($urandom % 4) == 0;
            set_s0(2'($urandom), $urandom % 8, $urandom % 8, 1'($urandom), $urandom % 8, 1'($urandom));
            set_s1(2'($urandom), $urandom % 8, $urandom % 8, 1'($urandom), $urandom % 8, 1'($urandom));
            e0 = RW'($urandom % 8); e1 = RW'($urandom % 8);
            m0 = RW'($urandom % 8); m1 = RW'($urandom % 8);
            w0 = RW'($urandom % 8); w1 = RW'($urandom % 8);
            el0 = 1'($urandom); el1 = 1'($urandom); ml0 = 1'($urandom); ml1 = 1'($urandom);
            rst_n = ($urandom % 150) != 0;
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule